// File: doc/BRIEF.md
# Keyboard-to-Host Serial Frame Receiver

This block sits on the host side of a two-wire keyboard link. The keyboard drives the clock line and the data line. The receiver brings both open-drain inputs into the system clock domain and filters out short glitches. It then follows each frame: a start bit held high for a possibly long first clock-low phase, eight data bits sent least significant bit first, one odd-parity bit, and a stop condition in which the keyboard pulls data low while the clock stays high. Each of these bits is sampled on a rising clock edge, so the value taken is the one present while the clock is high.

A finished byte leaves the block through a valid/ready output. `rx_valid` rises once the stop condition has been seen. It stays high, with `rx_data` and `rx_parity_err` unchanged, until a cycle in which `rx_ready` is also high. The link itself has no flow control, so back-pressure uses the line's own hold-off: while a byte waits unaccepted, the block drives the data line low. Driving data low is also how `inhibit_i` stops the keyboard from sending. A frame that stalls, starts badly or loses its stop condition is dropped and reported with a one-cycle `frame_err` pulse. All timing thresholds are counts of system clock cycles, set by parameters.

Top module: `kbd_frame_rx`

## Requirements
- R1: The byte presented on `rx_data` is made of the data-line levels seen at the 2nd through 9th filtered rising edges of the link clock in a frame. The 2nd edge gives bit 0 and the 9th edge gives bit 7.
- R2: The level at the 10th rising edge is the parity bit. `rx_parity_err` is 1 exactly when the eight data bits plus the parity bit hold an even number of ones. It is presented together with its byte.
- R3: A frame begins at a filtered falling edge of the link clock while the receiver is idle. If the data line is low at the first rising edge, the block pulses `frame_err` and delivers no byte.
- R4: A first low phase of any length shorter than `TIMEOUT_CYC` cycles is accepted, and the frame is received normally.
- R5: While a frame is in progress, if no link clock edge arrives for `TIMEOUT_CYC` cycles, the partial frame is discarded. `frame_err` is high for exactly one cycle and no byte is delivered.
- R6: A byte is delivered only after the parity bit, once the data line is seen low while the clock is high. If the clock falls again before that happens, `frame_err` pulses and no byte is delivered.
- R7: Once `rx_valid` is high, it stays high, with `rx_data` and `rx_parity_err` stable, until a clock edge at which `rx_ready` is also high. After that edge `rx_valid` is low unless a new byte finished in the same cycle.
- R8: While `rx_valid` is high and `rx_ready` is low, `kbd_data_oe` is 1, so the data line is held low.
- R9: While `inhibit_i` is 1, `kbd_data_oe` is 1 and any frame in progress is abandoned. No byte is delivered and `frame_err` does not pulse. After release, the next frame is received normally.
- R10: A low pulse on the link clock shorter than `FILTER_CYC` system cycles starts no frame and causes no error.
- R11: After reset, `rx_valid`, `frame_err` and `kbd_data_oe` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| kbd_clk_i | input | 1 | Link clock line as read from the pin |
| kbd_data_i | input | 1 | Link data line as read from the pin |
| kbd_data_oe | output | 1 | 1 pulls the data line low (inhibit or back-pressure) |
| inhibit_i | input | 1 | 1 holds off the keyboard and abandons any frame |
| rx_data | output | DATA_W | Received byte |
| rx_parity_err | output | 1 | Parity check failed for `rx_data` |
| rx_valid | output | 1 | Byte available |
| rx_ready | input | 1 | Consumer accepts the byte |
| frame_err | output | 1 | One-cycle pulse when a frame is dropped |

## Verification
The hardest state to reach from the ports is the stop-wait window after the parity bit. A wrong-parity frame has to arrive at this window with the data line already low, and a frame with parity bit 1 has to see the clock fall again instead of the stop condition. The keyboard model in the bench makes both cases: it can force the parity bit, and it can replace the stop condition with an extra clock pulse. Abandoning a frame on inhibit is reached by raising `inhibit_i` from inside the model, in the middle of the fourth data bit, while the link clock keeps running.

// File: rtl/kbd_rx_pkg.sv
package kbd_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_BITS  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/kbd_line_filter.sv
// Brings one open-drain line into the clock domain. The output level only
// changes after the synchronised input has disagreed with it for FILT_CYC
// consecutive cycles.
module kbd_line_filter #(
  parameter int   SYNC_STAGES = 2,
  parameter int   FILT_CYC    = 8,
  parameter logic RST_VAL     = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o
);
  localparam int CW = (FILT_CYC > 1) ? $clog2(FILT_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   synced;
  logic [CW-1:0]          agree_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= {SYNC_STAGES{RST_VAL}};
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
  end

  assign synced = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_o   <= RST_VAL;
      agree_cnt <= '0;
    end else if (synced == level_o) begin
      agree_cnt <= '0;
    end else if (agree_cnt == LAST) begin
      level_o   <= synced;
      agree_cnt <= '0;
    end else begin
      agree_cnt <= agree_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/kbd_rx_timeout.sv
// Counts cycles since the last link clock edge while a frame is open.
module kbd_rx_timeout #(
  parameter int LIMIT = 125000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic kick_i,
  output logic expired_o
);
  localparam int TW = $clog2(LIMIT + 1);
  localparam logic [TW-1:0] LAST = TW'(LIMIT - 1);

  logic [TW-1:0] idle_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                idle_cnt <= '0;
    else if (!run_i || kick_i) idle_cnt <= '0;
    else if (idle_cnt != LAST) idle_cnt <= idle_cnt + 1'b1;
  end

  assign expired_o = run_i && !kick_i && (idle_cnt == LAST);
endmodule

// File: rtl/kbd_rx_deframer.sv
// Frame sequencer: start check, DATA_W+1 samples on rising edges, stop wait.
module kbd_rx_deframer
  import kbd_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              data_i,
  input  logic              timeout_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              ferr_o,
  output logic [DATA_W-1:0] byte_o,
  output logic              perr_o
);
  localparam int NB  = DATA_W + 1;
  localparam int BCW = $clog2(NB);
  localparam logic [BCW-1:0] LAST_BIT = BCW'(DATA_W);

  rx_state_e      state_q;
  logic [BCW-1:0] bit_q;
  logic [NB-1:0]  shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      bit_q   <= '0;
      shift_q <= '0;
      done_o  <= 1'b0;
      ferr_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      ferr_o <= 1'b0;
      if (abort_i) begin
        state_q <= RX_IDLE;
      end else begin
        unique case (state_q)
          RX_IDLE: begin
            if (fall_i) state_q <= RX_START;
          end
          RX_START: begin
            if (timeout_i) begin
              ferr_o  <= 1'b1;
              state_q <= RX_IDLE;
            end else if (rise_i) begin
              bit_q <= '0;
              if (data_i) begin
                state_q <= RX_BITS;
              end else begin
                ferr_o  <= 1'b1;
                state_q <= RX_IDLE;
              end
            end
          end
          RX_BITS: begin
            if (timeout_i) begin
              ferr_o  <= 1'b1;
              state_q <= RX_IDLE;
            end else if (rise_i) begin
              shift_q <= {data_i, shift_q[NB-1:1]};
              if (bit_q == LAST_BIT) state_q <= RX_STOP;
              else                   bit_q   <= bit_q + 1'b1;
            end
          end
          RX_STOP: begin
            if (timeout_i || fall_i) begin
              ferr_o  <= 1'b1;
              state_q <= RX_IDLE;
            end else if (!data_i) begin
              done_o  <= 1'b1;
              state_q <= RX_IDLE;
            end
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign busy_o = (state_q != RX_IDLE);
  assign byte_o = shift_q[DATA_W-1:0];
  assign perr_o = ~(^shift_q);
endmodule

// File: rtl/kbd_frame_rx.sv
module kbd_frame_rx #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int FILTER_CYC  = 8,
  parameter int TIMEOUT_CYC = 125000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kbd_clk_i,
  input  logic              kbd_data_i,
  output logic              kbd_data_oe,
  input  logic              inhibit_i,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_parity_err,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              frame_err
);
  localparam int NLINES = 2;
  localparam logic [NLINES-1:0] LINE_RST = 2'b01;

  logic [NLINES-1:0] raw_lines;
  logic [NLINES-1:0] line_lvl;
  logic              clk_lvl_q;
  logic              clk_rise;
  logic              clk_fall;
  logic              hold;
  logic              abort;
  logic              busy;
  logic              expired;
  logic              done;
  logic              ferr;
  logic [DATA_W-1:0] frame_byte;
  logic              frame_perr;

  assign raw_lines = {kbd_data_i, kbd_clk_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    kbd_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_CYC   (FILTER_CYC),
      .RST_VAL    (LINE_RST[g])
    ) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (raw_lines[g]),
      .level_o(line_lvl[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_lvl_q <= 1'b1;
    else        clk_lvl_q <= line_lvl[0];
  end

  assign clk_rise = line_lvl[0] && !clk_lvl_q;
  assign clk_fall = !line_lvl[0] && clk_lvl_q;

  assign hold        = rx_valid && !rx_ready;
  assign abort       = inhibit_i || hold;
  assign kbd_data_oe = abort;

  kbd_rx_timeout #(.LIMIT(TIMEOUT_CYC)) u_tmo (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (busy),
    .kick_i   (clk_rise || clk_fall),
    .expired_o(expired)
  );

  kbd_rx_deframer #(.DATA_W(DATA_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .abort_i  (abort),
    .rise_i   (clk_rise),
    .fall_i   (clk_fall),
    .data_i   (line_lvl[1]),
    .timeout_i(expired),
    .busy_o   (busy),
    .done_o   (done),
    .ferr_o   (ferr),
    .byte_o   (frame_byte),
    .perr_o   (frame_perr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid      <= 1'b0;
      rx_data       <= '0;
      rx_parity_err <= 1'b0;
    end else if (done) begin
      rx_valid      <= 1'b1;
      rx_data       <= frame_byte;
      rx_parity_err <= frame_perr;
    end else if (rx_ready) begin
      rx_valid      <= 1'b0;
    end
  end

  assign frame_err = ferr;
endmodule

// File: rtl/kbd_frame_rx_chk.sv
module kbd_frame_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              kbd_data_oe,
  input logic              inhibit_i,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_parity_err,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              frame_err
);
  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data) && $stable(rx_parity_err)));

  assert_backpressure_oe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |-> kbd_data_oe);

  assert_inhibit_oe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit_i |-> kbd_data_oe);

  assert_inhibit_no_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit_i |=> !frame_err);

  assert_inhibit_no_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit_i |-> ##2 !$rose(rx_valid));

  assert_err_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err);
endmodule

bind kbd_frame_rx kbd_frame_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .kbd_data_oe  (kbd_data_oe),
  .inhibit_i    (inhibit_i),
  .rx_data      (rx_data),
  .rx_parity_err(rx_parity_err),
  .rx_valid     (rx_valid),
  .rx_ready     (rx_ready),
  .frame_err    (frame_err)
);

// File: tb/kbd_frame_rx_bench.sv
module kbd_frame_rx_bench;
  localparam int HI  = 40;
  localparam int LO  = 20;
  localparam int TMO = 300;

  typedef struct packed {
    logic [7:0] b;
    logic       flip;
    logic       bad_start;
    logic [9:0] slen;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{b: 8'h00, flip: 1'b0, bad_start: 1'b0, slen: 10'd30},
    '{b: 8'hFF, flip: 1'b0, bad_start: 1'b0, slen: 10'd30},
    '{b: 8'hA5, flip: 1'b0, bad_start: 1'b0, slen: 10'd60},
    '{b: 8'h3C, flip: 1'b1, bad_start: 1'b0, slen: 10'd30},
    '{b: 8'h81, flip: 1'b0, bad_start: 1'b0, slen: 10'd250},
    '{b: 8'h5A, flip: 1'b0, bad_start: 1'b1, slen: 10'd30},
    '{b: 8'h01, flip: 1'b1, bad_start: 1'b0, slen: 10'd30}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       kb_clk = 1'b1;
  logic       kb_data = 1'b0;
  logic       inhibit = 1'b0;
  logic       ready = 1'b1;
  logic       data_oe;
  logic       data_line;
  logic [7:0] rx_data;
  logic       rx_perr;
  logic       rx_valid;
  logic       ferr;

  int         n_checks = 0;
  int         n_fail = 0;
  int         n_beats = 0;
  int         n_ferr = 0;
  logic [7:0] last_b = '0;
  logic       last_pe = 1'b0;
  bit         finished = 1'b0;

  always #4 clk = ~clk;

  assign data_line = kb_data & ~data_oe;

  kbd_frame_rx #(.FILTER_CYC(4), .TIMEOUT_CYC(TMO)) u_kbd_frame_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .kbd_clk_i    (kb_clk),
    .kbd_data_i   (data_line),
    .kbd_data_oe  (data_oe),
    .inhibit_i    (inhibit),
    .rx_data      (rx_data),
    .rx_parity_err(rx_perr),
    .rx_valid     (rx_valid),
    .rx_ready     (ready),
    .frame_err    (ferr)
  );

  always @(posedge clk) begin
    if (rst_n) begin
      if (rx_valid && ready) begin
        n_beats <= n_beats + 1;
        last_b  <= rx_data;
        last_pe <= rx_perr;
      end
      if (ferr) n_ferr <= n_ferr + 1;
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Keyboard model: start low phase, then nine bit clocks, then stop.
  task automatic send_frame(input logic [7:0] b, input logic par, input logic st,
                            input int slen, input bit stop, input int inh_at);
    kb_clk = 1'b0;
    wait_n(3);
    kb_data = st;
    wait_n(slen);
    kb_clk = 1'b1;
    wait_n(HI);
    if (!st) begin
      kb_data = 1'b0;
      wait_n(HI);
      return;
    end
    for (int i = 0; i < 9; i++) begin
      kb_clk = 1'b0;
      if (i == inh_at) inhibit = 1'b1;
      wait_n(3);
      kb_data = (i < 8) ? b[i] : par;
      wait_n(LO - 3);
      kb_clk = 1'b1;
      wait_n(HI);
    end
    if (stop) begin
      kb_data = 1'b0;
    end else begin
      kb_clk = 1'b0;
      wait_n(LO);
      kb_clk = 1'b1;
      kb_data = 1'b0;
    end
    wait_n(HI);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int beats0;
    int ferr0;
    wait_n(5);
    // R11: reset state
    chk("R11 rx_valid", {31'd0, rx_valid}, 32'd0);
    chk("R11 frame_err", {31'd0, ferr}, 32'd0);
    chk("R11 kbd_data_oe", {31'd0, data_oe}, 32'd0);
    rst_n = 1'b1;
    wait_n(20);

    // Table walk: R1 R2 R3 R4
    for (int v = 0; v < 7; v++) begin
      logic par;
      par = (~^VECS[v].b) ^ VECS[v].flip;
      beats0 = n_beats;
      ferr0 = n_ferr;
      send_frame(VECS[v].b, par, ~VECS[v].bad_start, int'(VECS[v].slen), 1'b1, -1);
      wait_n(60);
      if (VECS[v].bad_start) begin
        chk("R3 start error pulse", n_ferr - ferr0, 32'd1);
        chk("R3 no byte", n_beats - beats0, 32'd0);
      end else begin
        chk("R1 R4 one byte", n_beats - beats0, 32'd1);
        chk("R1 byte value", {24'd0, last_b}, {24'd0, VECS[v].b});
        chk("R2 parity flag", {31'd0, last_pe}, {31'd0, VECS[v].flip});
        chk("R4 no error", n_ferr - ferr0, 32'd0);
      end
    end

    // R5: clock stuck low past the timeout
    beats0 = n_beats;
    ferr0 = n_ferr;
    kb_clk = 1'b0;
    wait_n(TMO + 100);
    kb_clk = 1'b1;
    wait_n(60);
    chk("R5 timeout error", n_ferr - ferr0, 32'd1);
    chk("R5 no byte", n_beats - beats0, 32'd0);

    // R6: extra clock instead of stop (0x00 carries parity 1)
    beats0 = n_beats;
    ferr0 = n_ferr;
    send_frame(8'h00, 1'b1, 1'b1, 30, 1'b0, -1);
    wait_n(60);
    chk("R6 missing stop error", n_ferr - ferr0, 32'd1);
    chk("R6 no byte", n_beats - beats0, 32'd0);

    // R10: short glitch on clock line while idle
    beats0 = n_beats;
    ferr0 = n_ferr;
    kb_clk = 1'b0;
    wait_n(2);
    kb_clk = 1'b1;
    wait_n(TMO + 100);
    chk("R10 glitch no error", n_ferr - ferr0, 32'd0);
    chk("R10 glitch no byte", n_beats - beats0, 32'd0);

    // R7 R8: back-pressure
    ready = 1'b0;
    send_frame(8'hC3, 1'b1, 1'b1, 30, 1'b1, -1);
    wait_n(60);
    chk("R7 valid held", {31'd0, rx_valid}, 32'd1);
    chk("R8 data line held low", {31'd0, data_oe}, 32'd1);
    wait_n(50);
    chk("R7 still valid", {31'd0, rx_valid}, 32'd1);
    chk("R7 data stable", {24'd0, rx_data}, 32'hC3);
    beats0 = n_beats;
    ready = 1'b1;
    wait_n(1);
    chk("R7 accepted", n_beats - beats0, 32'd1);
    chk("R7 valid dropped", {31'd0, rx_valid}, 32'd0);
    chk("R8 line released", {31'd0, data_oe}, 32'd0);

    // R9: inhibit raised mid-frame
    beats0 = n_beats;
    ferr0 = n_ferr;
    send_frame(8'h96, 1'b1, 1'b1, 30, 1'b1, 3);
    wait_n(60);
    chk("R9 oe during inhibit", {31'd0, data_oe}, 32'd1);
    chk("R9 no byte", n_beats - beats0, 32'd0);
    chk("R9 no error", n_ferr - ferr0, 32'd0);
    inhibit = 1'b0;
    wait_n(20);
    send_frame(8'h42, 1'b1, 1'b1, 30, 1'b1, -1);
    wait_n(60);
    chk("R9 resume byte count", n_beats - beats0, 32'd1);
    chk("R9 resume byte", {24'd0, last_b}, 32'h42);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule